// File: doc/BRIEF.md
# Memory-Mapped Switch Register Bridge

This block lets a host processor reach the internal registers of a switch core, where each register is named by a page number and a register number. The host sees a small set of 32-bit registers: a command word, two words of outgoing data, two words of returned data and a control word. The switch core sees a request/acknowledge port that carries page, register, direction and 64-bit data in both directions.

Before any access, the host must own the bridge. It raises a request bit in the control word and waits for the grant bit. With the grant held, the host loads the outgoing data words if the access is a write. It then writes the command word with the go bit set. The go bit reads back as 1 while the switch access is open and drops by itself once the switch acknowledges. For a read, the result is then in the two returned-data words. Values narrower than 64 bits sit in the low-order bits: 8-, 16- and 32-bit values use the low word only, and 48-bit values use the whole low word plus the bottom 16 bits of the high word.

Top module: `sw_reg_bridge`

## Requirements
- R1: After reset, and at any moment reset is asserted, every register reads 0, the grant is dropped, `sw_req` is 0 and no access is open. The one exception is the init-done bit, which always shows its input.
- R2: Control word at offset 0x40. Bit 3 is the host request and can be written. Bit 4 is the grant. The grant rises exactly one cycle after the request bit is set and falls exactly one cycle after it is cleared. Writing bit 4 has no effect.
- R3: Control bit 6 is read-only and reflects `sw_init_done` in the same cycle.
- R4: Command word at offset 0x2C. Bit 0 is go, bit 1 is write (1) or read (0), bits 23:16 are the register number and bits 31:24 are the page. A command accepted with go=1 and bit 2 clear drives `sw_req` high from the next cycle, with `sw_page`, `sw_regnum` and `sw_write` taken from that word. The command reads back as page, register, write flag and go bit, with all other bits 0.
- R5: A command word written while the grant is 0 is ignored. No access starts, go stays 0 and the stored page, register and write fields keep their values.
- R6: The go bit reads 1 from the cycle after an accepted launch until the clock edge at which `sw_ack` is seen with `sw_req` high. It reads 0 from then on.
- R7: Command words written while go reads 1 are dropped. The open access and the stored fields are unchanged.
- R8: Outgoing data is written at offsets 0x30 (high word) and 0x34 (low word), and `sw_wdata` equals {high, low}. Writes to these two offsets while an access is open are dropped.
- R9: Returned data is read at offsets 0x38 (high word, `sw_rdata[63:32]`) and 0x3C (low word, `sw_rdata[31:0]`). These words load only at an acknowledge of an open read. An acknowledge of a write, an acknowledge with no open request, and host writes to these offsets leave them unchanged.
- R10: An accepted command word with bit 2 set clears all four data words and starts no access, even if go is also set.
- R11: `sw_req` stays high, with page, register, write flag and write data held steady, until `sw_ack`. Each launch produces exactly one acknowledged access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_wr | input | 1 | Host write strobe, one cycle per write |
| hb_addr | input | ADDR_W | Host byte offset, used for both writes and reads |
| hb_wdata | input | 32 | Host write data |
| hb_rdata | output | 32 | Contents of the register at `hb_addr`, combinational |
| sw_init_done | input | 1 | Switch core reports that its initialisation has finished |
| sw_req | output | 1 | Switch access request |
| sw_page | output | 8 | Page number of the access |
| sw_regnum | output | 8 | Register number within the page |
| sw_write | output | 1 | 1 for a write access, 0 for a read access |
| sw_wdata | output | 64 | Data for a write access |
| sw_ack | input | 1 | One-cycle acknowledge from the switch core |
| sw_rdata | input | 64 | Read result, valid together with `sw_ack` |

## Verification
Register writes take effect at the clock edge that follows the strobe. The bench drives and samples on falling edges, so every written value, including a launched `sw_req`, is checked at the first falling edge after the write. The grant is checked twice: still low at that first falling edge, and high one falling edge later. It is checked the same way when it is released. The go bit is checked as 1 on every falling edge while the switch model withholds its acknowledge. It is checked as 0, with new returned data, at the falling edge that follows the acknowledge edge. Since host reads are combinational, each readback happens one nanosecond after the address is set and never crosses a clock edge.

// File: rtl/swb_pkg.sv
package swb_pkg;

  localparam int unsigned HOST_W   = 32;
  localparam int unsigned SW_W     = 2 * HOST_W;
  localparam int unsigned PAGE_W   = 8;
  localparam int unsigned REGN_W   = 8;

  // host register offsets (software depends on these)
  localparam int unsigned OFF_CMD  = 'h2C;
  localparam int unsigned OFF_WDH  = 'h30;
  localparam int unsigned OFF_WDL  = 'h34;
  localparam int unsigned OFF_RDH  = 'h38;
  localparam int unsigned OFF_RDL  = 'h3C;
  localparam int unsigned OFF_CTRL = 'h40;

  // command word fields
  localparam int unsigned CMD_GO   = 0;
  localparam int unsigned CMD_WR   = 1;
  localparam int unsigned CMD_CLR  = 2;
  localparam int unsigned CMD_REG  = 16;
  localparam int unsigned CMD_PAGE = 24;

  // control word fields
  localparam int unsigned CTL_REQ  = 3;
  localparam int unsigned CTL_GNT  = 4;
  localparam int unsigned CTL_INIT = 6;

  typedef enum logic {ACC_IDLE, ACC_OPEN} acc_state_t;

  function automatic logic [HOST_W-1:0] pack_cmd(input logic [PAGE_W-1:0] pg,
                                                 input logic [REGN_W-1:0] rn,
                                                 input logic wr,
                                                 input logic go);
    logic [HOST_W-1:0] w;
    w = '0;
    w[CMD_PAGE +: PAGE_W] = pg;
    w[CMD_REG  +: REGN_W] = rn;
    w[CMD_WR]             = wr;
    w[CMD_GO]             = go;
    return w;
  endfunction

  function automatic logic [HOST_W-1:0] pack_ctrl(input logic req,
                                                  input logic gnt,
                                                  input logic init);
    logic [HOST_W-1:0] w;
    w = '0;
    w[CTL_REQ]  = req;
    w[CTL_GNT]  = gnt;
    w[CTL_INIT] = init;
    return w;
  endfunction

endpackage

// File: rtl/swb_grant.sv
module swb_grant (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic grant_o
);
  // ownership answers the request one cycle later, both ways
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grant_o <= 1'b0;
    else        grant_o <= req_i;
  end
endmodule

// File: rtl/swb_access.sv
module swb_access
  import swb_pkg::*;
#(
  parameter int unsigned PW = PAGE_W,
  parameter int unsigned RW = REGN_W,
  parameter int unsigned DW = SW_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic          cmd_launch,
  input  logic [PW-1:0] cmd_page,
  input  logic [RW-1:0] cmd_reg,
  input  logic          cmd_wr,
  input  logic [DW-1:0] wd_word,
  input  logic          sw_ack,
  output logic          busy_o,
  output logic          rd_load_o,
  output logic          sw_req,
  output logic [PW-1:0] sw_page,
  output logic [RW-1:0] sw_regnum,
  output logic          sw_write,
  output logic [DW-1:0] sw_wdata
);
  acc_state_t state_q;
  logic [PW-1:0] page_q;
  logic [RW-1:0] reg_q;
  logic          wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ACC_IDLE;
      page_q  <= '0;
      reg_q   <= '0;
      wr_q    <= 1'b0;
    end else begin
      if (cmd_we) begin
        page_q <= cmd_page;
        reg_q  <= cmd_reg;
        wr_q   <= cmd_wr;
      end
      case (state_q)
        ACC_IDLE: if (cmd_launch) state_q <= ACC_OPEN;
        ACC_OPEN: if (sw_ack)     state_q <= ACC_IDLE;
        default:                  state_q <= ACC_IDLE;
      endcase
    end
  end

  always_comb begin
    busy_o    = (state_q == ACC_OPEN);
    sw_req    = busy_o;
    sw_page   = page_q;
    sw_regnum = reg_q;
    sw_write  = wr_q;
    sw_wdata  = wd_word;
    rd_load_o = busy_o && sw_ack && !wr_q;
  end
endmodule

// File: rtl/swb_regs.sv
module swb_regs
  import swb_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned HW     = HOST_W,
  parameter int unsigned PW     = PAGE_W,
  parameter int unsigned RW     = REGN_W,
  localparam int unsigned DW    = 2 * HW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hb_wr,
  input  logic [ADDR_W-1:0] hb_addr,
  input  logic [HW-1:0]     hb_wdata,
  output logic [HW-1:0]     hb_rdata,
  input  logic              grant,
  input  logic              busy,
  input  logic [PW-1:0]     fld_page,
  input  logic [RW-1:0]     fld_reg,
  input  logic              fld_wr,
  input  logic              init_done,
  input  logic              rd_load,
  input  logic [DW-1:0]     rd_in,
  output logic              req_bit,
  output logic              cmd_we,
  output logic              cmd_launch,
  output logic              data_clear,
  output logic [DW-1:0]     wd_word,
  output logic [DW-1:0]     rd_word
);
  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned off);
    return a == ADDR_W'(off);
  endfunction

  logic wr_cmd, wr_ctrl;

  always_comb begin
    wr_cmd     = hb_wr && hit(hb_addr, OFF_CMD);
    wr_ctrl    = hb_wr && hit(hb_addr, OFF_CTRL);
    cmd_we     = wr_cmd && grant && !busy;
    cmd_launch = cmd_we && hb_wdata[CMD_GO] && !hb_wdata[CMD_CLR];
    data_clear = cmd_we && hb_wdata[CMD_CLR];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       req_bit <= 1'b0;
    else if (wr_ctrl) req_bit <= hb_wdata[CTL_REQ];
  end

  // outgoing data words: index 0 = low, 1 = high
  for (genvar g = 0; g < 2; g++) begin : g_wd
    localparam int unsigned OFF = (g == 0) ? OFF_WDL : OFF_WDH;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        wd_word[g*HW +: HW] <= '0;
      else if (data_clear)
        wd_word[g*HW +: HW] <= '0;
      else if (hb_wr && hit(hb_addr, OFF) && !busy)
        wd_word[g*HW +: HW] <= hb_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rd_word <= '0;
    else if (data_clear) rd_word <= '0;
    else if (rd_load)    rd_word <= rd_in;
  end

  always_comb begin
    hb_rdata = '0;
    if (hit(hb_addr, OFF_CMD))  hb_rdata = pack_cmd(fld_page, fld_reg, fld_wr, busy);
    if (hit(hb_addr, OFF_WDH))  hb_rdata = wd_word[HW +: HW];
    if (hit(hb_addr, OFF_WDL))  hb_rdata = wd_word[0 +: HW];
    if (hit(hb_addr, OFF_RDH))  hb_rdata = rd_word[HW +: HW];
    if (hit(hb_addr, OFF_RDL))  hb_rdata = rd_word[0 +: HW];
    if (hit(hb_addr, OFF_CTRL)) hb_rdata = pack_ctrl(req_bit, grant, init_done);
  end
endmodule

// File: rtl/sw_reg_bridge.sv
module sw_reg_bridge
  import swb_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hb_wr,
  input  logic [ADDR_W-1:0] hb_addr,
  input  logic [HOST_W-1:0] hb_wdata,
  output logic [HOST_W-1:0] hb_rdata,
  input  logic              sw_init_done,
  output logic              sw_req,
  output logic [PAGE_W-1:0] sw_page,
  output logic [REGN_W-1:0] sw_regnum,
  output logic              sw_write,
  output logic [SW_W-1:0]   sw_wdata,
  input  logic              sw_ack,
  input  logic [SW_W-1:0]   sw_rdata
);
  logic            req_bit, grant, busy, rd_load;
  logic            cmd_we, cmd_launch, data_clear;
  logic [SW_W-1:0] wd_word, rd_word;

  swb_grant i_grant (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_bit),
    .grant_o (grant)
  );

  swb_regs #(.ADDR_W(ADDR_W)) i_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .hb_wr      (hb_wr),
    .hb_addr    (hb_addr),
    .hb_wdata   (hb_wdata),
    .hb_rdata   (hb_rdata),
    .grant      (grant),
    .busy       (busy),
    .fld_page   (sw_page),
    .fld_reg    (sw_regnum),
    .fld_wr     (sw_write),
    .init_done  (sw_init_done),
    .rd_load    (rd_load),
    .rd_in      (sw_rdata),
    .req_bit    (req_bit),
    .cmd_we     (cmd_we),
    .cmd_launch (cmd_launch),
    .data_clear (data_clear),
    .wd_word    (wd_word),
    .rd_word    (rd_word)
  );

  swb_access i_access (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_we     (cmd_we),
    .cmd_launch (cmd_launch),
    .cmd_page   (hb_wdata[CMD_PAGE +: PAGE_W]),
    .cmd_reg    (hb_wdata[CMD_REG +: REGN_W]),
    .cmd_wr     (hb_wdata[CMD_WR]),
    .wd_word    (wd_word),
    .sw_ack     (sw_ack),
    .busy_o     (busy),
    .rd_load_o  (rd_load),
    .sw_req     (sw_req),
    .sw_page    (sw_page),
    .sw_regnum  (sw_regnum),
    .sw_write   (sw_write),
    .sw_wdata   (sw_wdata)
  );
endmodule

// File: rtl/swb_checker.sv
module swb_checker
  import swb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_bit,
  input logic              grant,
  input logic              busy,
  input logic              data_clear,
  input logic              sw_req,
  input logic              sw_ack,
  input logic              sw_write,
  input logic [PAGE_W-1:0] sw_page,
  input logic [REGN_W-1:0] sw_regnum,
  input logic [SW_W-1:0]   sw_wdata,
  input logic [SW_W-1:0]   rd_word
);
  AST_GRANT_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    grant == $past(req_bit)); // R2

  AST_NO_START_UNGRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant && !busy) |=> !sw_req); // R5

  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && sw_ack) |=> !busy); // R6

  AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(sw_page) && $stable(sw_regnum) && $stable(sw_write))); // R7

  AST_WDATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && !sw_ack) |=> $stable(sw_wdata)); // R8

  AST_RDATA_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!(sw_req && sw_ack && !sw_write) && !data_clear) |=> $stable(rd_word)); // R9

  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && !sw_ack) |=> sw_req); // R11
endmodule

bind sw_reg_bridge swb_checker i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_bit    (req_bit),
  .grant      (grant),
  .busy       (busy),
  .data_clear (data_clear),
  .sw_req     (sw_req),
  .sw_ack     (sw_ack),
  .sw_write   (sw_write),
  .sw_page    (sw_page),
  .sw_regnum  (sw_regnum),
  .sw_wdata   (sw_wdata),
  .rd_word    (rd_word)
);

// File: tb/test_sw_reg_bridge.sv
module test_sw_reg_bridge;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CMD = 8'h2C, A_WDH = 8'h30, A_WDL = 8'h34,
                         A_RDH = 8'h38, A_RDL = 8'h3C, A_CTL = 8'h40;

  // vector: {write, page, reg, ack latency, data}
  localparam int NV = 6;
  localparam logic [84:0] VEC [NV] = '{
    {1'b1, 8'h01, 8'h10, 4'd0, 64'h0000_0000_0000_00A5},
    {1'b0, 8'h02, 8'h20, 4'd2, 64'h1122_3344_5566_7788},
    {1'b1, 8'hFF, 8'hFE, 4'd3, 64'h0000_BEEF_CAFE_F00D},
    {1'b0, 8'h80, 8'h01, 4'd1, 64'h0000_0000_0000_1234},
    {1'b1, 8'h3C, 8'h7F, 4'd5, 64'hFFFF_FFFF_FFFF_FFFF},
    {1'b0, 8'h00, 8'h00, 4'd0, 64'hDEAD_BEEF_0BAD_F00D}
  };

  logic        clk = 1'b0, rst_n = 1'b0, hb_wr = 1'b0;
  logic [7:0]  hb_addr = '0;
  logic [31:0] hb_wdata = '0, hb_rdata;
  logic        sw_init_done = 1'b0, sw_req, sw_write, sw_ack = 1'b0;
  logic [7:0]  sw_page, sw_regnum;
  logic [63:0] sw_wdata, sw_rdata = '0;

  int checks = 0, errors = 0;
  logic [63:0] rd_exp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sw_reg_bridge i_sw_reg_bridge (
    .clk(clk), .rst_n(rst_n), .hb_wr(hb_wr), .hb_addr(hb_addr),
    .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .sw_init_done(sw_init_done),
    .sw_req(sw_req), .sw_page(sw_page), .sw_regnum(sw_regnum),
    .sw_write(sw_write), .sw_wdata(sw_wdata), .sw_ack(sw_ack),
    .sw_rdata(sw_rdata)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    hb_wr = 1'b1; hb_addr = a; hb_wdata = d;
    @(negedge clk);
    hb_wr = 1'b0;
  endtask

  task automatic hread(input logic [7:0] a, output logic [31:0] v);
    hb_addr = a;
    #1 v = hb_rdata;
  endtask

  function automatic logic [31:0] cmd(input logic [7:0] pg, input logic [7:0] rn,
                                      input logic wr, input logic clr, input logic go);
    return {pg, rn, 13'd0, clr, wr, go};
  endfunction

  // acknowledge after lat cycles; go must read 1 until then and 0 after
  task automatic serve(input int lat, input logic [63:0] rdat, input string tag);
    logic [31:0] v;
    for (int i = 0; i < lat; i++) begin
      hread(A_CMD, v);
      chk({tag, " R6 go while open"}, {63'd0, v[0]}, 64'd1);
      chk({tag, " R11 req held"}, {63'd0, sw_req}, 64'd1);
      @(negedge clk);
    end
    sw_ack = 1'b1; sw_rdata = rdat;
    @(negedge clk);
    sw_ack = 1'b0; sw_rdata = 64'h5A5A_5A5A_5A5A_5A5A;
    hread(A_CMD, v);
    chk({tag, " R6 go clears after ack"}, {63'd0, v[0]}, 64'd0);
    chk({tag, " R11 req drops after ack"}, {63'd0, sw_req}, 64'd0);
  endtask

  task automatic check_rd(input string tag);
    logic [31:0] h, l;
    hread(A_RDH, h); hread(A_RDL, l);
    chk({tag, " R9 returned data"}, {h, l}, rd_exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, h, l;
    // ---- R1 reset state
    repeat (3) @(negedge clk);
    hread(A_CMD, v); chk("R1 cmd in reset", {32'd0, v}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    hread(A_CTL, v); chk("R1 ctrl after reset", {32'd0, v}, 64'd0);
    hread(A_WDH, h); hread(A_WDL, l); chk("R1 wdata after reset", {h, l}, 64'd0);
    check_rd("R1");
    chk("R1 sw_req after reset", {63'd0, sw_req}, 64'd0);

    // ---- R3 init-done mirrors input
    sw_init_done = 1'b1; hread(A_CTL, v);
    chk("R3 init bit high", {32'd0, v}, 64'h40);
    sw_init_done = 1'b0; hread(A_CTL, v);
    chk("R3 init bit low", {32'd0, v}, 64'h0);
    sw_init_done = 1'b1;

    // ---- R5 command without grant
    hwrite(A_CMD, cmd(8'h77, 8'h66, 1'b1, 1'b0, 1'b1));
    for (int i = 0; i < 3; i++) begin
      chk("R5 no request ungranted", {63'd0, sw_req}, 64'd0);
      @(negedge clk);
    end
    hread(A_CMD, v); chk("R5 cmd unchanged ungranted", {32'd0, v}, 64'd0);

    // ---- R2 grant cannot be written, then follows request
    hwrite(A_CTL, 32'h10);
    @(negedge clk);
    hread(A_CTL, v); chk("R2 grant not writable", {32'd0, v}, 64'h40);
    hwrite(A_CTL, 32'h08);
    hread(A_CTL, v); chk("R2 grant not yet", {32'd0, v}, 64'h48);
    @(negedge clk);
    hread(A_CTL, v); chk("R2 grant one cycle later", {32'd0, v}, 64'h58);

    // ---- table walk: R4 R6 R8 R9 R11
    for (int k = 0; k < NV; k++) begin
      logic        w;
      logic [7:0]  pg, rn;
      int          lat;
      logic [63:0] d;
      {w, pg, rn} = VEC[k][84:68];
      lat = int'(VEC[k][67:64]);
      d = VEC[k][63:0];
      if (w) begin
        hwrite(A_WDH, d[63:32]);
        hwrite(A_WDL, d[31:0]);
      end
      hwrite(A_CMD, cmd(pg, rn, w, 1'b0, 1'b1));
      chk("R4 request launched", {63'd0, sw_req}, 64'd1);
      chk("R4 page", {56'd0, sw_page}, {56'd0, pg});
      chk("R4 register", {56'd0, sw_regnum}, {56'd0, rn});
      chk("R4 direction", {63'd0, sw_write}, {63'd0, w});
      hread(A_CMD, v); chk("R4 cmd readback", {32'd0, v}, {32'd0, cmd(pg, rn, w, 1'b0, 1'b1)});
      if (w) chk("R8 write data to switch", sw_wdata, d);
      serve(lat, w ? 64'hABAB_ABAB_ABAB_ABAB : d, "vec");
      if (!w) rd_exp = d;
      check_rd(w ? "vec write ack" : "vec read ack");
    end

    // ---- R7 R8 writes while busy are dropped
    hwrite(A_WDH, 32'h0102_0304);
    hwrite(A_WDL, 32'h0506_0708);
    hwrite(A_CMD, cmd(8'h11, 8'h22, 1'b1, 1'b0, 1'b1));
    hwrite(A_CMD, cmd(8'h99, 8'h88, 1'b0, 1'b0, 1'b1));
    hwrite(A_WDL, 32'hFFFF_0000);
    chk("R7 page held", {56'd0, sw_page}, 64'h11);
    chk("R7 direction held", {63'd0, sw_write}, 64'd1);
    chk("R8 wdata held while busy", sw_wdata, 64'h0102_0304_0506_0708);
    serve(0, 64'h0, "busy-drop");
    hread(A_CMD, v); chk("R7 fields after access", {32'd0, v}, {32'd0, cmd(8'h11, 8'h22, 1'b1, 1'b0, 1'b0)});
    hread(A_WDL, v); chk("R8 low word kept", {32'd0, v}, 64'h0506_0708);
    check_rd("R9 after write ack");

    // ---- R9 host writes and stray acknowledge ignored
    hwrite(A_RDL, 32'h1234_5678);
    hwrite(A_RDH, 32'h9ABC_DEF0);
    check_rd("R9 host write ignored");
    @(negedge clk);
    sw_ack = 1'b1; sw_rdata = 64'h7777_7777_7777_7777;
    @(negedge clk);
    sw_ack = 1'b0;
    check_rd("R9 stray ack ignored");
    chk("R11 no request from stray ack", {63'd0, sw_req}, 64'd0);

    // ---- R10 clear bit
    hwrite(A_CMD, cmd(8'h44, 8'h55, 1'b0, 1'b1, 1'b1));
    chk("R10 no launch", {63'd0, sw_req}, 64'd0);
    hread(A_CMD, v); chk("R10 go not set", {63'd0, v[0]}, 64'd0);
    hread(A_WDH, h); hread(A_WDL, l); chk("R10 wdata cleared", {h, l}, 64'd0);
    rd_exp = '0;
    check_rd("R10");

    // ---- R2 release
    hwrite(A_CTL, 32'h0);
    hread(A_CTL, v); chk("R2 grant held one cycle", {32'd0, v}, 64'h50);
    @(negedge clk);
    hread(A_CTL, v); chk("R2 grant released", {32'd0, v}, 64'h40);

    // ---- R1 reset during an open access
    hwrite(A_CTL, 32'h08);
    @(negedge clk);
    hwrite(A_WDL, 32'h0000_00FF);
    hwrite(A_CMD, cmd(8'h12, 8'h34, 1'b0, 1'b0, 1'b1));
    chk("R1 access open before reset", {63'd0, sw_req}, 64'd1);
    rst_n = 1'b0;
    #1;
    chk("R1 request dropped by reset", {63'd0, sw_req}, 64'd0);
    hread(A_CMD, v); chk("R1 cmd cleared by reset", {32'd0, v}, 64'd0);
    hread(A_CTL, v); chk("R1 grant cleared by reset", {32'd0, v}, 64'h40);
    hread(A_WDL, v); chk("R1 wdata cleared by reset", {32'd0, v}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule